// File: doc/BRIEF.md
# Lockdown-Aware Cache Victim Selector

This block picks the destination segment for every linefill of a four-segment set-associative cache, and lets software pin lines into chosen segments. A small lockdown register holds a fill-pinning flag and a two-bit segment boundary. When the flag is set, every fill goes to the segment that the boundary names. Software uses this to load code or data into one segment at a time. When the flag is clear, victims rotate round-robin over the segments at or above the boundary. The segments below the boundary keep their contents.

A fill starts on a miss request or on an explicit preload request. Both kinds are handled the same way. The block holds a busy flag from the cycle after it accepts a request until the fill-complete strobe arrives. While busy, it ignores further requests. A register write that arrives during a fill is held back and takes effect only when the fill completes. A boundary value of 3 is kept and read back as written, so software can see that no segment is left to lock.

Top module: `lkv_victim_sel`

## Requirements
- R1: After reset the fill-pinning flag and the boundary are 0, `cfg_rdata` is 0, `busy` is 0 and `victim` is 0.
- R2: A write sets the flag from bit 31 and the boundary from bits 1:0 of `cfg_wdata`, and ignores all other bits. `cfg_rdata` returns the flag at bit 31 and the boundary at bits 1:0, with every other bit zero.
- R3: While the flag is 1, every accepted fill puts the boundary value on `victim`.
- R4: While the flag is 0, accepted fills walk up through the segments from the boundary to 3 and then wrap back to the boundary. After reset the walk starts at segment 0. Fills made while the flag is 1 do not move the walk.
- R5: While the flag is 0, no segment numbered below the boundary is ever chosen. With a boundary of 3, only segment 3 is chosen.
- R6: When idle, `miss_req` or `preload_req`, alone or together, starts exactly one fill. `busy` and `victim` update one cycle later.
- R7: A request that arrives while `busy` is 1 is ignored. `busy` and `victim` stay unchanged.
- R8: `fill_done` while busy clears `busy` one cycle later. `fill_done` while idle has no effect.
- R9: A write while busy leaves `cfg_rdata` unchanged until the cycle after `fill_done`. At that point the most recent held write becomes visible.
- R10: A write while idle is visible one cycle later. A request in the same cycle uses the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Lockdown register write strobe |
| cfg_wdata | input | 32 | Lockdown register write value |
| cfg_rdata | output | 32 | Lockdown register read value |
| miss_req | input | 1 | Linefill request from a miss |
| preload_req | input | 1 | Explicit preload linefill request |
| fill_done | input | 1 | Linefill-complete strobe |
| victim | output | 2 | Segment chosen for the current fill |
| busy | output | 1 | A linefill is in progress |

## Verification
A corrupted round-robin pointer shows up on `victim` at the next accepted fill. It appears either as a skipped segment or as a locked segment being chosen. A held register write that is lost or applied too early changes `cfg_rdata` in the cycle after the fill completes, or during the fill itself. A stuck busy state is visible on `busy`, and on `victim` at the first request after `fill_done`. For these reasons the bench compares all three outputs with its model after every clock, so a fault appears within one cycle of the stimulus that exposes it.

// File: rtl/lkv_pkg.sv
package lkv_pkg;
    localparam int SEG_W    = 2;
    localparam int NSEG     = 1 << SEG_W;
    localparam int WORD_W   = 32;
    localparam int LOAD_POS = WORD_W - 1;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic pin;
        seg_t bound;
    } lock_cfg_t;

    function automatic lock_cfg_t cfg_from_word(input word_t w);
        lock_cfg_t c;
        c.pin   = w[LOAD_POS];
        c.bound = w[SEG_W-1:0];
        return c;
    endfunction

    function automatic word_t cfg_to_word(input lock_cfg_t c);
        word_t w;
        w = '0;
        w[LOAD_POS]  = c.pin;
        w[SEG_W-1:0] = c.bound;
        return w;
    endfunction

    function automatic seg_t lift_to_floor(input seg_t ptr, input seg_t floor);
        return (ptr < floor) ? floor : ptr;
    endfunction
endpackage

// File: rtl/lkv_lockreg.sv
module lkv_lockreg
    import lkv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  word_t     wdata,
    input  logic      busy,
    input  logic      fill_done,
    output lock_cfg_t cfg
);
    lock_cfg_t held;
    logic      held_vld;
    lock_cfg_t eff;
    logic      eff_vld;

    always_comb begin
        eff_vld = wr | held_vld;
        eff     = wr ? cfg_from_word(wdata) : held;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            held     <= '0;
            held_vld <= 1'b0;
        end else if (!busy) begin
            if (wr) cfg <= cfg_from_word(wdata);
            held_vld <= 1'b0;
        end else if (fill_done) begin
            if (eff_vld) cfg <= eff;
            held_vld <= 1'b0;
        end else begin
            held     <= eff;
            held_vld <= eff_vld;
        end
    end

    // R9
    hold_during_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fill_done) |=> $stable(cfg));
endmodule

// File: rtl/lkv_busy.sv
module lkv_busy (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic fill_done,
    output logic busy,
    output logic accept
);
    assign accept = req & ~busy;

    always_ff @(posedge clk) begin
        if (rst)            busy <= 1'b0;
        else if (accept)    busy <= 1'b1;
        else if (fill_done) busy <= 1'b0;
    end

    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && fill_done) |=> !busy);
    // R6
    accept_sets_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
endmodule

// File: rtl/lkv_rr_pick.sv
module lkv_rr_pick
    import lkv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  lock_cfg_t cfg,
    output seg_t      victim
);
    seg_t rr;
    seg_t pick;

    always_comb begin
        if (cfg.pin) pick = cfg.bound;
        else         pick = lift_to_floor(rr, cfg.bound);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr     <= '0;
            victim <= '0;
        end else if (accept) begin
            victim <= pick;
            if (!cfg.pin) rr <= pick + seg_t'(1);
        end
    end

    // R3
    pinned_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && cfg.pin) |=> (victim == $past(cfg.bound)));
    // R5
    locked_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !cfg.pin) |=> (victim >= $past(cfg.bound)));
endmodule

// File: rtl/lkv_victim_sel.sv
module lkv_victim_sel
    import lkv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        miss_req,
    input  logic        preload_req,
    input  logic        fill_done,
    output logic [1:0]  victim,
    output logic        busy
);
    lock_cfg_t cfg;
    logic      accept;
    seg_t      vsel;

    lkv_busy u_busy (
        .clk(clk), .rst(rst), .req(miss_req | preload_req),
        .fill_done(fill_done), .busy(busy), .accept(accept)
    );

    lkv_lockreg u_lock (
        .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
        .busy(busy), .fill_done(fill_done), .cfg(cfg)
    );

    lkv_rr_pick u_pick (
        .clk(clk), .rst(rst), .accept(accept), .cfg(cfg), .victim(vsel)
    );

    assign victim    = vsel;
    assign cfg_rdata = cfg_to_word(cfg);

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fill_done) |=> (busy && $stable(victim)));
    // R2
    rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[30:2] == '0);
endmodule

// File: tb/lkv_victim_sel_test.sv
module lkv_victim_sel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        miss_req = 1'b0;
    logic        preload_req = 1'b0;
    logic        fill_done = 1'b0;
    logic [1:0]  victim;
    logic        busy;

    int total = 0;
    int bad   = 0;

    int m_pin, m_bnd, m_rr, m_busy, m_vic, m_hvld, m_hpin, m_hbnd;

    always #5 clk = ~clk;

    lkv_victim_sel uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .miss_req(miss_req), .preload_req(preload_req),
        .fill_done(fill_done), .victim(victim), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_rd();
        return {m_pin[0], 29'b0, m_bnd[1:0]};
    endfunction

    task automatic compare(input string tag);
        chk({tag, " victim"}, {30'b0, victim}, m_vic);
        chk({tag, " busy"}, {31'b0, busy}, m_busy);
        chk({tag, " rdata"}, cfg_rdata, m_rd());
    endtask

    task automatic step(input logic f, input logic p, input logic d,
                        input logic w, input logic [31:0] wd, input string tag);
        int npin, nbnd;
        miss_req = f; preload_req = p; fill_done = d; cfg_wr = w; cfg_wdata = wd;
        npin = wd[31]; nbnd = wd[1:0];
        if (m_busy == 1) begin
            if (w) begin m_hvld = 1; m_hpin = npin; m_hbnd = nbnd; end
            if (d) begin
                if (m_hvld == 1) begin m_pin = m_hpin; m_bnd = m_hbnd; end
                m_hvld = 0;
                m_busy = 0;
            end
        end else begin
            if (f || p) begin
                if (m_pin == 1) m_vic = m_bnd;
                else begin
                    m_vic = (m_rr < m_bnd) ? m_bnd : m_rr;
                    m_rr = (m_vic + 1) % 4;
                end
                m_busy = 1;
            end
            if (w) begin m_pin = npin; m_bnd = nbnd; end
        end
        @(posedge clk);
        @(negedge clk);
        miss_req = 0; preload_req = 0; fill_done = 0; cfg_wr = 0;
        compare(tag);
    endtask

    task automatic fill(input logic pre, input string tag);
        step(!pre, pre, 0, 0, 0, tag);
        step(1, 1, 0, 0, 0, {tag, " R7"});
        step(0, 0, 1, 0, 0, {tag, " R8"});
    endtask

    initial begin
        m_pin = 0; m_bnd = 0; m_rr = 0; m_busy = 0; m_vic = 0; m_hvld = 0;
        m_hpin = 0; m_hbnd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare("R1 reset");

        // R2: junk bits ignored, readback placement
        step(0, 0, 0, 1, 32'h7FFF_FFFE, "R2 write");
        chk("R2 readback", cfg_rdata, 32'h0000_0002);
        step(0, 0, 0, 1, 32'h0000_0000, "R2 clear");
        // R8 idle done ignored
        step(0, 0, 1, 0, 0, "R8 idle done");
        // R4 rotation over all four
        for (int i = 0; i < 5; i++) begin
            fill(0, "R4 rotate");
            chk("R4 order", {30'b0, victim}, m_vic);
        end
        // R6 both requests at once: one fill
        step(1, 1, 0, 0, 0, "R6 both");
        chk("R6 busy", {31'b0, busy}, 1);
        step(0, 0, 1, 0, 0, "R6 done");
        // lock segment 0 with preloads (R3)
        step(0, 0, 0, 1, 32'h8000_0000, "R10 pin0");
        for (int i = 0; i < 3; i++) begin
            fill(1, "R3 preload");
            chk("R3 seg0", {30'b0, victim}, 0);
        end
        // R9 write during fill is held
        step(0, 1, 0, 0, 0, "R9 start");
        step(0, 0, 0, 1, 32'h8000_0003, "R9 held");
        chk("R9 unchanged", cfg_rdata, 32'h8000_0000);
        step(0, 0, 0, 1, 32'h8000_0001, "R9 latest");
        step(0, 0, 1, 0, 0, "R9 applied");
        chk("R9 visible", cfg_rdata, 32'h8000_0001);
        for (int i = 0; i < 3; i++) begin
            fill(1, "R3 preload");
            chk("R3 seg1", {30'b0, victim}, 1);
        end
        // R10 write and request same cycle uses old value
        step(1, 0, 0, 1, 32'h0000_0002, "R10 same");
        chk("R10 old value", {30'b0, victim}, 1);
        step(0, 0, 1, 0, 0, "R10 done");
        // R5 many misses with boundary 2
        for (int i = 0; i < 40; i++) begin
            fill(0, "R5 miss");
            chk("R5 no locked", {31'b0, victim >= 2'd2}, 1);
        end
        // boundary 3 only segment 3
        step(0, 0, 0, 1, 32'h0000_0003, "R5 bound3");
        chk("R2 bound3 read", cfg_rdata, 32'h0000_0003);
        for (int i = 0; i < 4; i++) begin
            fill(i[0], "R5 b3");
            chk("R5 only3", {30'b0, victim}, 3);
        end
        // back to boundary 0: rotation resumes
        step(0, 0, 0, 1, 32'h0000_0000, "R4 unlock");
        for (int i = 0; i < 6; i++) fill(0, "R4 resume");
        // reset again
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0;
        m_pin = 0; m_bnd = 0; m_rr = 0; m_busy = 0; m_vic = 0; m_hvld = 0;
        compare("R1 re-reset");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule